// File: doc/BRIEF.md
# SHA-256 Message Schedule Expander (four words per step)

This block grows a SHA-256 message schedule from a 16-word block. It keeps the sixteen most recent 32-bit schedule words in a sliding window. Each step request produces the next four words at once, presented as one 128-bit vector with a one-cycle valid pulse. Twelve steps turn W[0..15] into W[16..63]. After the twelfth step the block reports completion and waits for a new block.

A step runs in two phases. The first phase forms, for all four lanes, the sum of the word sixteen positions back and the small-sigma-0 of the word fifteen back. The second phase adds the small-sigma-1 of the word two back and the word seven back. Lanes 2 and 3 depend on lanes 0 and 1 of the same step. The `SPLIT_FINISH` parameter chooses how that is resolved. With 0, one combinational chain finishes all four lanes in a single cycle. With 1, lanes 0 and 1 are registered first and lanes 2 and 3 are finished in a following cycle.

Top module: `sha256_sched_expander`

## Requirements
- R1: A `load` pulse captures the block, with word W[j] taken from `blk_in[32*j+31:32*j]` for j = 0..15. In the following cycle `out_valid` and `done` are 0. A load has priority over a step request in the same cycle.
- R2: The small-sigma-0 term is rotr(x,7) XOR rotr(x,18) XOR (x >> 3).
- R3: The small-sigma-1 term is rotr(x,17) XOR rotr(x,19) XOR (x >> 10).
- R4: Each new word is W[i] = σ1(W[i-2]) + W[i-7] + σ0(W[i-15]) + W[i-16] modulo 2^32. Lane k of `words_out` (bits 32*k+31:32*k) carries W[i+k].
- R5: Lanes 2 and 3 use the lane 0 and lane 1 words produced in the same step as their W[i-2] operand.
- R6: After each step the window advances by four words. Consecutive steps after a load deliver W[16..19], W[20..23] and so on up to W[60..63].
- R7: Suppose a step request is sampled at a rising edge while the block is idle. `out_valid` is then high after the third following edge (counting that one) when `SPLIT_FINISH`=0, and after the fourth when `SPLIT_FINISH`=1.
- R8: `out_valid` is high for exactly one cycle per completed step.
- R9: Step requests that arrive while a step is in progress are ignored. They neither start an extra step nor advance the schedule.
- R10: `done` rises together with the valid pulse of the twelfth step. While `done` is high, step requests produce no valid and leave `words_out` unchanged until the next load.
- R11: A load during a step in progress aborts it. No valid is produced for that step, and the schedule restarts from the new block.
- R12: While reset is held, `out_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Capture `blk_in` as W[0..15] and restart |
| blk_in | input | 512 | Sixteen block words, W[0] in the low 32 bits |
| step | input | 1 | Request the next four schedule words |
| words_out | output | 128 | Four new words, lane 0 in the low 32 bits |
| out_valid | output | 1 | One-cycle pulse when `words_out` holds a new group |
| done | output | 1 | All twelve steps completed for the current block |

## Verification
The bench builds two copies side by side from the same stimulus: one with `SPLIT_FINISH`=0 (the single-cycle combinational chain) and one with `SPLIT_FINISH`=1 (the two-sub-cycle finish). Running both at once lets a single run measure the three-cycle and four-cycle latencies, and shows that both ways of resolving the same-step dependence of lanes 2 and 3 produce identical words. `STEPS` stays at its default of 12, so the full sweep from W[16] to W[63] and the completion behaviour are reached in every block.

// File: rtl/sha256_sched_expander.sv
module sha256_sched_expander #(
  parameter int STEPS        = 12,
  parameter int SPLIT_FINISH = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [511:0] blk_in,
  input  logic         step,
  output logic [127:0] words_out,
  output logic         out_valid,
  output logic         done
);

  localparam int CW = $clog2(STEPS + 1);

  typedef enum logic [1:0] {S_IDLE, S_PART, S_FIN, S_FIN_HI} st_t;

  function automatic logic [31:0] rotr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [31:0] sig0(input logic [31:0] x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic logic [31:0] sig1(input logic [31:0] x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  st_t         st;
  logic [CW-1:0] cnt;
  logic [31:0] win  [16];
  logic [31:0] part [4];
  logic [31:0] part_n [4];
  logic [31:0] new_w [4];
  logic [31:0] lo_src [2];
  logic        finish;

  for (genvar k = 0; k < 4; k++) begin : g_part
    assign part_n[k] = win[k] + sig0(win[k+1]);
  end

  assign new_w[0] = part[0] + sig1(win[14]) + win[9];
  assign new_w[1] = part[1] + sig1(win[15]) + win[10];
  assign new_w[2] = part[2] + sig1(lo_src[0]) + win[11];
  assign new_w[3] = part[3] + sig1(lo_src[1]) + win[12];

  if (SPLIT_FINISH != 0) begin : g_split
    logic [31:0] lo_q [2];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[0] <= '0;
        lo_q[1] <= '0;
      end else if (st == S_FIN) begin
        lo_q[0] <= new_w[0];
        lo_q[1] <= new_w[1];
      end
    end
    assign lo_src[0] = lo_q[0];
    assign lo_src[1] = lo_q[1];
    assign finish    = (st == S_FIN_HI);
  end else begin : g_chain
    assign lo_src[0] = new_w[0];
    assign lo_src[1] = new_w[1];
    assign finish    = (st == S_FIN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      done      <= 1'b0;
      out_valid <= 1'b0;
      words_out <= '0;
      for (int j = 0; j < 16; j++) win[j] <= '0;
      for (int k = 0; k < 4; k++) part[k] <= '0;
    end else begin
      out_valid <= 1'b0;
      if (load) begin
        st   <= S_IDLE;
        cnt  <= '0;
        done <= 1'b0;
        for (int j = 0; j < 16; j++) win[j] <= blk_in[32*j +: 32];
      end else begin
        case (st)
          S_IDLE:   if (step && !done) st <= S_PART;
          S_PART: begin
            for (int k = 0; k < 4; k++) part[k] <= part_n[k];
            st <= S_FIN;
          end
          S_FIN:    if (!finish) st <= S_FIN_HI;
          default:  ;
        endcase
        if (finish) begin
          st        <= S_IDLE;
          words_out <= {new_w[3], new_w[2], new_w[1], new_w[0]};
          for (int j = 0; j < 12; j++) win[j] <= win[j+4];
          for (int k = 0; k < 4; k++) win[12+k] <= new_w[k];
          cnt       <= cnt + 1'b1;
          out_valid <= 1'b1;
          if (cnt == CW'(STEPS - 1)) done <= 1'b1;
        end
      end
    end
  end

  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_load_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!out_valid && !done));

  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> !out_valid);

  assert_done_with_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> out_valid);

  assert_window_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (win[0] == $past(win[4])));

  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && !load) |=> (st != S_PART));

endmodule

// File: tb/tb_sha256_sched_expander.sv
module tb_sha256_sched_expander;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load = 1'b0;
  logic [511:0] blk_in = '0;
  logic         step = 1'b0;
  logic [127:0] wo_a, wo_b;
  logic         v_a, v_b, d_a, d_b;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] ref_w [64];
  int sidx;

  always #2.5 clk = ~clk;

  sha256_sched_expander #(.STEPS(12), .SPLIT_FINISH(0)) dut (
    .clk(clk), .rst_n(rst_n), .load(load), .blk_in(blk_in), .step(step),
    .words_out(wo_a), .out_valid(v_a), .done(d_a));

  sha256_sched_expander #(.STEPS(12), .SPLIT_FINISH(1)) dut_split (
    .clk(clk), .rst_n(rst_n), .load(load), .blk_in(blk_in), .step(step),
    .words_out(wo_b), .out_valid(v_b), .done(d_b));

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic build_ref(input logic [511:0] b);
    for (int j = 0; j < 16; j++) ref_w[j] = b[32*j +: 32];
    for (int i = 16; i < 64; i++) begin
      logic [31:0] s0, s1;
      s0 = rr(ref_w[i-15], 7) ^ rr(ref_w[i-15], 18) ^ (ref_w[i-15] >> 3);
      s1 = rr(ref_w[i-2], 17) ^ rr(ref_w[i-2], 19) ^ (ref_w[i-2] >> 10);
      ref_w[i] = s1 + ref_w[i-7] + s0 + ref_w[i-16];
    end
  endtask

  task automatic do_load(input logic [511:0] b);
    @(negedge clk);
    load = 1'b1; blk_in = b;
    @(negedge clk);
    load = 1'b0;
    chk("R1 valid/done clear", {126'd0, v_a | v_b, d_a | d_b}, '0);
    build_ref(b);
    sidx = 0;
  endtask

  task automatic do_step(input bit extra_pulses);
    int ca, cb, pa, pb;
    logic [127:0] exp;
    ca = 0; cb = 0; pa = 0; pb = 0;
    @(negedge clk);
    step = 1'b1;
    for (int c = 1; c <= 6; c++) begin
      @(negedge clk);
      step = extra_pulses && (c < 3);
      if (v_a) begin ca = c; pa++; end
      if (v_b) begin cb = c; pb++; end
      if (v_a) begin
        exp = {ref_w[16+4*sidx+3], ref_w[16+4*sidx+2], ref_w[16+4*sidx+1], ref_w[16+4*sidx]};
        chk("R4 words chain", wo_a, exp);
        chk("R5 upper lanes chain", {64'd0, wo_a[127:64]}, {64'd0, exp[127:64]});
      end
      if (v_b) begin
        exp = {ref_w[16+4*sidx+3], ref_w[16+4*sidx+2], ref_w[16+4*sidx+1], ref_w[16+4*sidx]};
        chk("R4 words split", wo_b, exp);
      end
    end
    step = 1'b0;
    chk("R7 latency chain", 128'(ca), 128'd3);
    chk("R7 latency split", 128'(cb), 128'd4);
    chk("R8 single pulse", 128'({pa, pb}), 128'({32'd1, 32'd1}));
    sidx++;
    chk("R10 done timing", {126'd0, d_a, d_b}, (sidx == 12) ? 128'd3 : 128'd0);
  endtask

  task automatic test_reset;
    @(negedge clk);
    chk("R12 reset state", {124'd0, v_a, v_b, d_a, d_b}, '0);
    rst_n = 1'b1;
  endtask

  task automatic test_abc;
    logic [511:0] b;
    b = '0;
    b[31:0] = 32'h61626380;
    b[511:480] = 32'h00000018;
    do_load(b);
    do_step(1'b0);
    chk("R3 sigma1 word W17", {96'd0, wo_a[63:32]}, {96'd0, 32'h000F0000});
    chk("R4 first word W16", {96'd0, wo_a[31:0]}, {96'd0, 32'h61626380});
    for (int s = 1; s < 12; s++) do_step(1'b0);
    chk("R6 last group W63", {96'd0, wo_a[127:96]}, {96'd0, ref_w[63]});
  endtask

  task automatic test_sigma0;
    logic [511:0] b;
    logic [31:0] x;
    x = 32'h80000001;
    b = '0;
    b[63:32] = x;
    do_load(b);
    do_step(1'b0);
    chk("R2 sigma0 only", {96'd0, wo_a[31:0]}, {96'd0, rr(x,7) ^ rr(x,18) ^ (x >> 3)});
  endtask

  task automatic test_busy_ignore;
    logic [511:0] b;
    for (int j = 0; j < 16; j++) b[32*j +: 32] = 32'h9E3779B9 * (j + 1) ^ 32'h5A5A0F0F;
    do_load(b);
    for (int s = 0; s < 4; s++) do_step(1'b1);
    chk("R9 schedule not advanced", {96'd0, wo_b[127:96]}, {96'd0, ref_w[31]});
  endtask

  task automatic test_done_ignore;
    logic [127:0] held;
    int pv;
    logic [511:0] b;
    b = {16{32'hFFFFFFFF}};
    do_load(b);
    for (int s = 0; s < 12; s++) do_step(1'b0);
    held = wo_a;
    pv = 0;
    @(negedge clk); step = 1'b1;
    @(negedge clk); step = 1'b0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (v_a || v_b) pv++;
    end
    chk("R10 no valid after done", 128'(pv), 128'd0);
    chk("R10 output held after done", wo_a, held);
  endtask

  task automatic test_abort;
    logic [511:0] b1, b2;
    int pv;
    for (int j = 0; j < 16; j++) begin
      b1[32*j +: 32] = 32'h01020304 << (j % 8);
      b2[32*j +: 32] = 32'hC0FFEE00 + 32'(j * 77);
    end
    do_load(b1);
    pv = 0;
    @(negedge clk); step = 1'b1;
    @(negedge clk); step = 1'b0; load = 1'b1; blk_in = b2;
    @(negedge clk); load = 1'b0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (v_a || v_b) pv++;
    end
    chk("R11 aborted step gives no valid", 128'(pv), 128'd0);
    build_ref(b2);
    sidx = 0;
    do_step(1'b0);
    chk("R11 restart from new block", wo_b, {ref_w[19], ref_w[18], ref_w[17], ref_w[16]});
  endtask

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    test_reset();
    test_abc();
    test_sigma0();
    test_busy_ignore();
    test_done_ignore();
    test_abort();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule